// File: doc/BRIEF.md
# Power-up and sleep sequencer for three step-down channels

This block turns three switching regulator channels on and off at the right moments. It stays in its reset state, and asks for a register reset, for as long as the supply is unqualified. A supply is unqualified while the undervoltage monitor reports not-ok, or while the overvoltage or over-temperature monitor reports a fault. Once the supply is good, the block counts a fixed settling delay in millisecond ticks. At the end of that delay it samples the low-input flag once, and this decides whether channels 1 and 2 run as pass-through switches or as regulators. It then turns the channels on one after another, with a fixed gap between them.

After power-up, the sleep pin is ignored for a long window. When sleep is later accepted, channel 2 turns off first and channel 1 turns off a stagger gap later. Channel 3 stays on and is told to move to its sleep voltage, but only if a channel 1 or 2 register enable was set when sleep began. When the sleep pin falls, channel 3 returns to its normal level, channel 1 comes back first and channel 2 follows. If any running channel loses power-good after its start-up window, the block turns every channel off without a register reset. It starts again from the settling delay once all three power-good flags are high.

Top module: `pmu_seq`

## Requirements
- R1: After reset, or in the cycles after uvlo_ok_i low, ovlo_i high or therm_i high, rst_req_o is 1 and en_o and byp_o are all 0. This holds until the supply is qualified again.
- R2: After the supply qualifies, en_o stays 0 through the first QUAL_MS-1 ticks (default 15 ms). Channel 1 (en_o[0]) turns on after tick QUAL_MS.
- R3: vin_low_i is sampled once, at the decision tick. If it was 1, byp_o[0] and byp_o[1] equal en_o[0] and en_o[1]; otherwise byp_o is 0. Later changes of vin_low_i have no effect.
- R4: Channel 2 (en_o[1]) turns on STAG_MS ticks after channel 1, and channel 3 (en_o[2]) turns on STAG_MS ticks after channel 2 (default 2 ms).
- R5: en_o[0] is forced to 0 while reg_en_i[0] is 0, and en_o[1] is forced to 0 while reg_en_i[1] is 0. No register bit gates channel 3.
- R6: sleep_i has no effect until SLP_IGN_MS ticks (default 1000) have passed since the decision tick.
- R7: When sleep is accepted, en_o[1] falls at once and en_o[0] falls STAG_MS ticks later. en_o[2] stays on.
- R8: slp_sel_o is 1 from sleep acceptance until sleep_i falls, but only if reg_en_i[0] or reg_en_i[1] was 1 at acceptance. Otherwise it stays 0.
- R9: When sleep_i falls, slp_sel_o returns to 0 and channel 1 turns on at once. Channel 2 follows STAG_MS ticks later.
- R10: An enabled channel whose pg_i bit is low after its start-up window turns all of en_o off, and rst_req_o stays 0. A low pg_i on a disabled channel is ignored. The block restarts with the qualification delay once pg_i is 3'b111.
- R11: A low pg_i bit is ignored while its channel has been enabled for fewer than PG_MASK_MS ticks (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| uvlo_ok_i | input | 1 | Supply above undervoltage threshold |
| ovlo_i | input | 1 | Overvoltage fault |
| therm_i | input | 1 | Over-temperature fault |
| vin_low_i | input | 1 | Input below the bypass decision level |
| sleep_i | input | 1 | Sleep request pin |
| pg_i | input | 3 | Per-channel power-good (85 % of target) |
| reg_en_i | input | 2 | Register enables for channels 1 and 2 |
| en_o | output | 3 | Per-channel enable |
| byp_o | output | 2 | Bypass mode for channels 1 and 2 |
| slp_sel_o | output | 1 | Channel 3 sleep-level select |
| rst_req_o | output | 1 | Full register reset request |

## Verification
The hardest situations to reach come after the 1000-tick sleep-ignore window. Sleep entry and exit with random register enables need a full power-up for every trial. The bench therefore holds sleep_i high from early in each power-up and checks the outputs one tick before arming and one tick after it. The power-good mask is reached by lowering a flag in the single tick between a channel's enable and the end of its window. A later drop of the same kind must then cause a shutdown.

// File: rtl/pmu_seq_pkg.sv
package pmu_seq_pkg;
  typedef enum logic [2:0] {
    S_OFF, S_QUAL, S_START, S_RUN, S_SDN, S_SLEEP, S_WAKE, S_PGFAIL
  } seq_state_e;
endpackage

// File: rtl/pmu_tick_timer.sv
module pmu_tick_timer #(
  parameter int unsigned MAX = 19,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_o <= '0;
    else if (clr_i)                             cnt_o <= '0;
    else if (tick_i && cnt_o != W'(MAX))        cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pmu_pg_window.sv
module pmu_pg_window #(
  parameter int unsigned MASK = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic pg_i,
  output logic bad_o
);
  localparam int unsigned W = $clog2(MASK + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!en_i)                         cnt_q <= '0;
    else if (tick_i && cnt_q != W'(MASK))   cnt_q <= cnt_q + 1'b1;
  end

  assign bad_o = en_i && (cnt_q == W'(MASK)) && !pg_i;
endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_seq_pkg::*;
#(
  parameter int unsigned QUAL_MS    = 15,
  parameter int unsigned STAG_MS    = 2,
  parameter int unsigned PG_MASK_MS = 4,
  parameter int unsigned SLP_IGN_MS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ms_tick_i,
  input  logic       uvlo_ok_i,
  input  logic       ovlo_i,
  input  logic       therm_i,
  input  logic       vin_low_i,
  input  logic       sleep_i,
  input  logic [2:0] pg_i,
  input  logic [1:0] reg_en_i,
  output logic [2:0] en_o,
  output logic [1:0] byp_o,
  output logic       slp_sel_o,
  output logic       rst_req_o
);
  localparam int unsigned NCH  = 3;
  localparam int unsigned TMAX = QUAL_MS + 2 * STAG_MS;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned AW   = $clog2(SLP_IGN_MS + 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0]  tcnt;
  logic [AW-1:0]  acnt;
  logic [NCH-1:0] en_q, on_c, bad;
  logic supply_ok, pg_bad, armed, byp_q, slp_q;

  assign supply_ok = uvlo_ok_i && !ovlo_i && !therm_i;
  assign pg_bad    = |bad;
  assign armed     = (acnt == AW'(SLP_IGN_MS));

  // phase timer restarts on every state change
  pmu_tick_timer #(.MAX(TMAX), .W(TW)) u_phase (
    .clk_i, .rst_ni, .clr_i(state_d != state_q), .tick_i(ms_tick_i), .cnt_o(tcnt)
  );

  // sleep arming counts from the decision tick
  pmu_tick_timer #(.MAX(SLP_IGN_MS), .W(AW)) u_arm (
    .clk_i, .rst_ni,
    .clr_i(state_q inside {S_OFF, S_QUAL, S_PGFAIL}),
    .tick_i(ms_tick_i), .cnt_o(acnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_pg
    pmu_pg_window #(.MASK(PG_MASK_MS)) u_win (
      .clk_i, .rst_ni, .tick_i(ms_tick_i), .en_i(en_q[g]), .pg_i(pg_i[g]), .bad_o(bad[g])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:    if (supply_ok) state_d = S_QUAL;
      S_QUAL:   if (tcnt == TW'(QUAL_MS)) state_d = S_START;
      S_START:  if (pg_bad) state_d = S_PGFAIL;
                else if (tcnt == TW'(2 * STAG_MS)) state_d = S_RUN;
      S_RUN:    if (pg_bad) state_d = S_PGFAIL;
                else if (sleep_i && armed) state_d = S_SDN;
      S_SDN:    if (pg_bad) state_d = S_PGFAIL;
                else if (tcnt == TW'(STAG_MS)) state_d = S_SLEEP;
      S_SLEEP:  if (pg_bad) state_d = S_PGFAIL;
                else if (!sleep_i) state_d = S_WAKE;
      S_WAKE:   if (pg_bad) state_d = S_PGFAIL;
                else if (tcnt == TW'(STAG_MS)) state_d = S_RUN;
      S_PGFAIL: if (&pg_i) state_d = S_QUAL;
      default:  state_d = S_OFF;
    endcase
    if (!supply_ok) state_d = S_OFF;
  end

  // channel requests per phase, bit0 = channel 1
  always_comb begin
    unique case (state_q)
      S_START: on_c = {1'b0, tcnt >= TW'(STAG_MS), 1'b1};
      S_RUN:   on_c = 3'b111;
      S_SDN:   on_c = 3'b101;
      S_SLEEP: on_c = 3'b100;
      S_WAKE:  on_c = 3'b101;
      default: on_c = 3'b000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      en_q    <= '0;
      byp_q   <= 1'b0;
      slp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= on_c & {1'b1, reg_en_i};
      if (state_q == S_QUAL && state_d == S_START) byp_q <= vin_low_i;
      else if (state_d == S_OFF)                   byp_q <= 1'b0;
      if (state_q == S_RUN && state_d == S_SDN)    slp_q <= |reg_en_i;
      else if (!(state_d inside {S_SDN, S_SLEEP})) slp_q <= 1'b0;
    end
  end

  assign en_o      = en_q;
  assign byp_o     = {2{byp_q}} & en_q[1:0];
  assign slp_sel_o = slp_q;
  assign rst_req_o = (state_q == S_OFF);
endmodule

// File: rtl/pmu_seq_chk.sv
module pmu_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uvlo_ok_i,
  input logic       ovlo_i,
  input logic       therm_i,
  input logic [1:0] reg_en_i,
  input logic [2:0] en_o,
  input logic       slp_sel_o,
  input logic       rst_req_o
);
  p_fault_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uvlo_ok_i || ovlo_i || therm_i) |=> rst_req_o);

  p_reset_all_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> (en_o == 3'b000));

  p_reg_gate_ch1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_i[0] |=> !en_o[0]);

  p_reg_gate_ch2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_i[1] |=> !en_o[1]);

  p_sleep_ch2_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slp_sel_o |=> !en_o[1]);

  p_sleep_ch3_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slp_sel_o |-> en_o[2]);
endmodule

bind pmu_seq pmu_seq_chk i_chk (.*);

// File: tb/test_pmu_seq.sv
module test_pmu_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 0, uvlo_ok = 0, ovlo = 0, therm = 0, vin_low = 0, sleep = 0;
  logic [2:0] pg = 3'b111;
  logic [1:0] reg_en = 2'b11;
  logic [2:0] en;
  logic [1:0] byp;
  logic slp_sel, rst_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pmu_seq i_pmu_seq (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick), .uvlo_ok_i(uvlo_ok),
    .ovlo_i(ovlo), .therm_i(therm), .vin_low_i(vin_low), .sleep_i(sleep),
    .pg_i(pg), .reg_en_i(reg_en), .en_o(en), .byp_o(byp),
    .slp_sel_o(slp_sel), .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (TICK_GAP) @(negedge clk);
    end
  endtask

  // expected enables k ticks after the decision tick
  function automatic logic [2:0] exp_start(input int k, input logic r1, input logic r2);
    return {k >= 4, r2 & (k >= 2), r1};
  endfunction

  function automatic logic [1:0] exp_byp(input logic v, input logic [2:0] e);
    return v ? e[1:0] : 2'b00;
  endfunction

  task automatic power_up(input logic v, input logic r1, input logic r2);
    reg_en = {r2, r1}; vin_low = v; ovlo = 0; therm = 0; uvlo_ok = 1;
    tick_n(QUAL_LAST);
    chk("R2", "en before delay end", en, 0);
    tick_n(1);
    chk("R2", "ch1 at decision", en, exp_start(0, r1, r2));
    vin_low = ~v;  // R3: later changes ignored
    tick_n(2);
    chk("R4", "ch2 after gap", en, exp_start(2, r1, r2));
    tick_n(2);
    chk("R4", "ch3 after gap", en, exp_start(4, r1, r2));
    chk("R3", "bypass", byp, exp_byp(v, exp_start(4, r1, r2)));
  endtask
  localparam int QUAL_LAST = 14;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "rst_req in reset", rst_req, 1);
    rst_n = 1'b1;
    tick_n(3);
    chk("R1", "rst_req no supply", rst_req, 1);
    chk("R1", "en no supply", en, 0);

    for (int it = 0; it < 5; it++) begin
      logic v, r1, r2;
      int f;
      v  = 1'($urandom);
      r1 = (it == 0) ? 1'b0 : (it == 1) ? 1'b1 : 1'($urandom);
      r2 = (it == 0) ? 1'b0 : (it == 1) ? 1'b1 : 1'($urandom);
      power_up(v, r1, r2);
      sleep = 1'b1;
      tick_n(995);
      chk("R6", "sleep before arming", en, {1'b1, r2, r1});
      chk("R6", "no sleep level yet", slp_sel, 0);
      tick_n(1);
      chk("R7", "ch2 off first", en, {1'b1, 1'b0, r1});
      chk("R8", "sleep level", slp_sel, r1 | r2);
      tick_n(1);
      chk("R7", "ch1 still on", en, {1'b1, 1'b0, r1});
      tick_n(1);
      chk("R7", "ch1 off later", en, 3'b100);
      sleep = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9", "ch1 back first", en, {1'b1, 1'b0, r1});
      chk("R9", "level restored", slp_sel, 0);
      tick_n(2);
      chk("R9", "ch2 back", en, {1'b1, r2, r1});
      f = $urandom % 3;
      if (f == 0) uvlo_ok = 0; else if (f == 1) ovlo = 1; else therm = 1;
      repeat (3) @(negedge clk);
      chk("R1", "fault rst_req", rst_req, 1);
      chk("R1", "fault en", en, 0);
      chk("R1", "fault byp", byp, 0);
      tick_n(2);
      chk("R1", "held during fault", en, 0);
    end

    // power-good masking and shutdown
    reg_en = 2'b11; vin_low = 0; ovlo = 0; therm = 0; uvlo_ok = 1;
    tick_n(15);
    chk("R2", "ch1 on", en, 3'b001);
    pg[0] = 1'b0;
    tick_n(1);
    chk("R11", "pg masked in window", en, 3'b001);
    pg[0] = 1'b1;
    tick_n(3);
    chk("R11", "start completed", en, 3'b111);
    reg_en = 2'b00;
    repeat (3) @(negedge clk);
    chk("R5", "reg bits off", en, 3'b100);
    reg_en = 2'b11;
    repeat (3) @(negedge clk);
    chk("R5", "reg bits on", en, 3'b111);
    tick_n(5);
    pg[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "shutdown en", en, 0);
    chk("R10", "no reg reset", rst_req, 0);
    tick_n(20);
    chk("R10", "held off", en, 0);
    pg[2] = 1'b1;
    tick_n(14);
    chk("R10", "restart delay", en, 0);
    tick_n(1);
    chk("R10", "restart ch1", en, 3'b001);
    tick_n(8);
    reg_en = 2'b01;
    repeat (3) @(negedge clk);
    pg[1] = 1'b0;
    tick_n(6);
    chk("R10", "disabled ch pg ignored", en, 3'b101);
    pg[1] = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule